// File: doc/BRIEF.md
# Data Address Translation and Fault Checker

This block sits behind a data TLB lookup in a processor's load/store path. Each request carries a 64-bit virtual address, an access size, a read/write flag and a few qualifiers: physical-mode, alternate-mode, page-table-entry load, and no-fault. Alongside it arrive the privilege state and the TLB lookup result for the same address. The block works out the physical address and picks one fault code, following a fixed precedence. The order is alignment, then physical bypass, then address validity, then the superpage window, then the TLB miss, then per-mode protection and the fault-on-read/fault-on-write traps, and last the physical range check.

Requests enter on a valid/ready handshake and results leave on another, through one register stage. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output slot is empty or is being drained in the same cycle. A result that is held by a low `rsp_ready` stays unchanged until it is taken. The block also holds three fault-logging registers that are visible as outputs: the faulting address, a packed memory-management status word, and a formatted page-table address. These registers are written on the edge that accepts a faulting request, unless that request asks for logging to be suppressed.

Top module: `dxlate_checker`

## Requirements
- R1: A request whose address is not a multiple of its size (2^`req_size_lg` bytes) gets fault code 1. This check comes before every other check, including physical mode. Its status flags carry only the write bit, which is bit 0.
- R2: The protection checks use an effective mode. It is `cur_mode` when `pc_lsb` is 0. When `pc_lsb` is 1, it is `alt_mode` if `req_alt` is set and kernel (mode 0) otherwise.
- R3: Outside physical mode, an address whose bits 63:42 are not all equal gets fault code 2. The status flags are access-violation (bit 1), bad-address (bit 5) and the write bit.
- R4: A valid address with bits 47:41 equal to 0x7E is a superpage. If `cur_mode` (not the effective mode) is not 0, it gets fault code 3 with the access-violation and write flags.
- R5: A permitted superpage access has a physical address made of VA bits 39:0. Bits 43:40 are all ones if VA bit 40 is 1, and all zeros otherwise.
- R6: A TLB miss gives fault code 5 for a page-table-entry load and code 4 otherwise. The flags are miss (bit 4) and the write bit.
- R7: On a TLB hit, the physical address is the PPN shifted left by 13 bits, concatenated with VA bits 12:0.
- R8: A write whose `tlb_wr_en` bit for the effective mode is 0 gets code 2, with flags write, access-violation, and fault-on-write (bit 3) if `tlb_fonw` is set. A permitted write with `tlb_fonw` set gets code 2 with flags write and fault-on-write.
- R9: A read whose `tlb_rd_en` bit for the effective mode is 0 gets code 3, with access-violation and fault-on-read (bit 2) if `tlb_fonr` is set. A permitted read with `tlb_fonr` set gets code 2 with the fault-on-read flag.
- R10: A logged fault writes three registers. `fault_va` takes the address. `mm_stat` takes {opcode[5:0], ra[4:0], flags[5:0]}, with the opcode at bit 11 and ra at bit 6. `va_form` takes `pt_base` OR (VA bits 42:13 shifted left by 3).
- R11: The fault registers keep their values in four cases: code 0, code 6, a page-table-entry load, or a no-fault request.
- R12: A request that has no other fault but whose physical address has any bit above bit 43 set gets code 6. In physical mode the physical address is the virtual address.
- R13: `req_ready` = !`rsp_valid` || `rsp_ready`. The result of an accepted request appears on the next cycle. A result that is held by a low `rsp_ready` keeps its value.
- R14: While reset is active, `rsp_valid` and all fault registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_va | input | 64 | Virtual address |
| req_size_lg | input | 2 | Log2 of access size in bytes |
| req_write | input | 1 | Write access |
| req_phys | input | 1 | Physical-mode access, no translation |
| req_alt | input | 1 | Use alternate mode when in privileged code |
| req_pte_load | input | 1 | Page-table-entry load |
| req_nofault | input | 1 | Suppress fault logging |
| pc_lsb | input | 1 | PC bit 0, set in privileged code |
| cur_mode | input | 2 | Current mode, 0 = kernel |
| alt_mode | input | 2 | Alternate mode |
| inst_opcode | input | 6 | Opcode of the faulting instruction |
| inst_ra | input | 5 | Register field of the faulting instruction |
| pt_base | input | 64 | Page-table base for the formatted address |
| tlb_hit | input | 1 | TLB lookup hit |
| tlb_ppn | input | 32 | Physical page number of hit entry |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fonr | input | 1 | Fault-on-read bit of hit entry |
| tlb_fonw | input | 1 | Fault-on-write bit of hit entry |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result can be taken |
| rsp_pa | output | 44 | Physical address |
| rsp_fault | output | 3 | Fault code, 0 = none |
| fault_va | output | 64 | Logged faulting address |
| mm_stat | output | 17 | Logged status word |
| va_form | output | 64 | Logged formatted address |

## Verification
The assertions assume that the TLB result and the privilege and instruction fields are steady and belong to the request in every cycle where `req_valid` is high. They also assume that `rsp_ready` only matters while `rsp_valid` is high. The bench changes all request-side inputs together at the falling edge and holds them until the request is accepted. Even the stalled request in the back-pressure test keeps its fields constant until it is taken. The bench keeps `pt_base` clear in bits 32:0, so the OR that builds the formatted address has a single expected result.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  typedef enum logic [2:0] {
    XF_NONE     = 3'd0,
    XF_ALIGN    = 3'd1,
    XF_FAULT    = 3'd2,
    XF_ACV      = 3'd3,
    XF_MISS     = 3'd4,
    XF_MISS_PTE = 3'd5,
    XF_MCHK     = 3'd6
  } xfault_e;

  localparam int FLAG_W   = 6;
  localparam int FL_WR    = 0;
  localparam int FL_ACV   = 1;
  localparam int FL_FONR  = 2;
  localparam int FL_FONW  = 3;
  localparam int FL_MISS  = 4;
  localparam int FL_BADVA = 5;
endpackage

// File: rtl/dxl_mode_sel.sv
module dxl_mode_sel #(
  parameter int MODE_W = 2
) (
  input  logic              pc_lsb,
  input  logic              alt_req,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] alt_mode,
  output logic [MODE_W-1:0] eff_mode
);
  always_comb begin
    if (!pc_lsb)      eff_mode = cur_mode;
    else if (alt_req) eff_mode = alt_mode;
    else              eff_mode = '0;
  end
endmodule

// File: rtl/dxl_fault_eval.sv
module dxl_fault_eval
  import dxl_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PA_W       = 44,
  parameter int PPN_W      = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int SEXT_BIT   = 42,
  parameter int SP_HI      = 47,
  parameter int SP_LO      = 41,
  parameter logic [SP_HI-SP_LO:0] SP_TAG = 7'h7E,
  parameter int SP_X_BIT   = 40,
  parameter int MODE_W     = 2
) (
  input  logic [VA_W-1:0]        va,
  input  logic [1:0]             size_lg,
  input  logic                   is_write,
  input  logic                   is_phys,
  input  logic                   is_pte,
  input  logic [MODE_W-1:0]      cur_mode,
  input  logic [MODE_W-1:0]      eff_mode,
  input  logic                   hit,
  input  logic [PPN_W-1:0]       ppn,
  input  logic [(1<<MODE_W)-1:0] rd_en,
  input  logic [(1<<MODE_W)-1:0] wr_en,
  input  logic                   fonr,
  input  logic                   fonw,
  output logic [VA_W-1:0]        pa_full,
  output xfault_e                code,
  output logic [FLAG_W-1:0]      flags
);
  localparam int SEXT_N = VA_W - SEXT_BIT;
  localparam int HIT_W  = PPN_W + PAGE_SHIFT;

  logic            misalign, bad_va, sp_hit, out_range;
  logic [VA_W-1:0] pa_sp, pa_hit;

  assign misalign  = (va[2:0] & ~(3'b111 << size_lg)) != 3'b000;
  assign bad_va    = (va[VA_W-1:SEXT_BIT] != {SEXT_N{1'b0}}) &&
                     (va[VA_W-1:SEXT_BIT] != {SEXT_N{1'b1}});
  assign sp_hit    = va[SP_HI:SP_LO] == SP_TAG;

  always_comb begin
    pa_sp = '0;
    pa_sp[SP_X_BIT-1:0]    = va[SP_X_BIT-1:0];
    pa_sp[PA_W-1:SP_X_BIT] = {(PA_W-SP_X_BIT){va[SP_X_BIT]}};
    pa_hit = '0;
    pa_hit[HIT_W-1:0] = {ppn, va[PAGE_SHIFT-1:0]};
  end

  assign out_range = pa_full[VA_W-1:PA_W] != '0;

  always_comb begin
    code    = XF_NONE;
    flags   = '0;
    pa_full = va;
    flags[FL_WR] = is_write;
    if (misalign) begin
      code = XF_ALIGN;
    end else if (is_phys) begin
      pa_full = va;
    end else if (bad_va) begin
      code = XF_FAULT;
      flags[FL_ACV]   = 1'b1;
      flags[FL_BADVA] = 1'b1;
    end else if (sp_hit) begin
      pa_full = pa_sp;
      if (cur_mode != '0) begin
        code = XF_ACV;
        flags[FL_ACV] = 1'b1;
      end
    end else if (!hit) begin
      code = is_pte ? XF_MISS_PTE : XF_MISS;
      flags[FL_MISS] = 1'b1;
    end else begin
      pa_full = pa_hit;
      if (is_write) begin
        if (!wr_en[eff_mode]) begin
          code = XF_FAULT;
          flags[FL_ACV]  = 1'b1;
          flags[FL_FONW] = fonw;
        end else if (fonw) begin
          code = XF_FAULT;
          flags[FL_FONW] = 1'b1;
        end
      end else begin
        if (!rd_en[eff_mode]) begin
          code = XF_ACV;
          flags[FL_ACV]  = 1'b1;
          flags[FL_FONR] = fonr;
        end else if (fonr) begin
          code = XF_FAULT;
          flags[FL_FONR] = 1'b1;
        end
      end
    end
    if (code == XF_NONE && out_range) code = XF_MCHK;
  end
endmodule

// File: rtl/dxl_fault_regs.sv
module dxl_fault_regs
  import dxl_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int SEXT_BIT   = 42,
  parameter int OPC_W      = 6,
  parameter int RA_W       = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fire,
  input  xfault_e                     code,
  input  logic                        is_pte,
  input  logic                        is_nofault,
  input  logic [VA_W-1:0]             va,
  input  logic [OPC_W-1:0]            opcode,
  input  logic [RA_W-1:0]             ra,
  input  logic [FLAG_W-1:0]           flags,
  input  logic [VA_W-1:0]             pt_base,
  output logic [VA_W-1:0]             fault_va,
  output logic [OPC_W+RA_W+FLAG_W-1:0] mm_stat,
  output logic [VA_W-1:0]             va_form
);
  localparam int VPN_W = SEXT_BIT - PAGE_SHIFT + 1;

  logic              log_en;
  logic [VPN_W-1:0]  vpn;

  assign vpn    = va[SEXT_BIT:PAGE_SHIFT];
  assign log_en = fire && code != XF_NONE && code != XF_MCHK &&
                  !is_pte && !is_nofault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_va <= '0;
      mm_stat  <= '0;
      va_form  <= '0;
    end else if (log_en) begin
      fault_va <= va;
      mm_stat  <= {opcode, ra, flags};
      va_form  <= pt_base | (VA_W'(vpn) << 3);
    end
  end

  assert_log_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (is_pte || is_nofault) |=>
      $stable(fault_va) && $stable(mm_stat) && $stable(va_form));

  assert_log_pack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    log_en |=> fault_va == $past(va) &&
               mm_stat[OPC_W+RA_W+FLAG_W-1:RA_W+FLAG_W] == $past(opcode) &&
               mm_stat[RA_W+FLAG_W-1:FLAG_W] == $past(ra));
endmodule

// File: rtl/dxlate_checker.sv
module dxlate_checker
  import dxl_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PA_W   = 44,
  parameter int PPN_W  = 32,
  parameter int MODE_W = 2,
  parameter int OPC_W  = 6,
  parameter int RA_W   = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [VA_W-1:0]              req_va,
  input  logic [1:0]                   req_size_lg,
  input  logic                         req_write,
  input  logic                         req_phys,
  input  logic                         req_alt,
  input  logic                         req_pte_load,
  input  logic                         req_nofault,
  input  logic                         pc_lsb,
  input  logic [MODE_W-1:0]            cur_mode,
  input  logic [MODE_W-1:0]            alt_mode,
  input  logic [OPC_W-1:0]             inst_opcode,
  input  logic [RA_W-1:0]              inst_ra,
  input  logic [VA_W-1:0]              pt_base,
  input  logic                         tlb_hit,
  input  logic [PPN_W-1:0]             tlb_ppn,
  input  logic [(1<<MODE_W)-1:0]       tlb_rd_en,
  input  logic [(1<<MODE_W)-1:0]       tlb_wr_en,
  input  logic                         tlb_fonr,
  input  logic                         tlb_fonw,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [PA_W-1:0]              rsp_pa,
  output logic [2:0]                   rsp_fault,
  output logic [VA_W-1:0]              fault_va,
  output logic [OPC_W+RA_W+FLAG_W-1:0] mm_stat,
  output logic [VA_W-1:0]              va_form
);
  localparam int PAGE_SHIFT = 13;
  localparam int SEXT_BIT   = 42;
  localparam int SP_HI      = 47;
  localparam int SP_LO      = 41;
  localparam logic [SP_HI-SP_LO:0] SP_TAG = 7'h7E;

  logic              fire;
  logic [MODE_W-1:0] eff_mode;
  logic [VA_W-1:0]   pa_full;
  xfault_e           code;
  logic [FLAG_W-1:0] flags;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  dxl_mode_sel #(.MODE_W(MODE_W)) u_mode (
    .pc_lsb(pc_lsb), .alt_req(req_alt), .cur_mode(cur_mode),
    .alt_mode(alt_mode), .eff_mode(eff_mode)
  );

  dxl_fault_eval #(
    .VA_W(VA_W), .PA_W(PA_W), .PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT),
    .SEXT_BIT(SEXT_BIT), .SP_HI(SP_HI), .SP_LO(SP_LO), .SP_TAG(SP_TAG),
    .SP_X_BIT(40), .MODE_W(MODE_W)
  ) u_eval (
    .va(req_va), .size_lg(req_size_lg), .is_write(req_write),
    .is_phys(req_phys), .is_pte(req_pte_load), .cur_mode(cur_mode),
    .eff_mode(eff_mode), .hit(tlb_hit), .ppn(tlb_ppn), .rd_en(tlb_rd_en),
    .wr_en(tlb_wr_en), .fonr(tlb_fonr), .fonw(tlb_fonw),
    .pa_full(pa_full), .code(code), .flags(flags)
  );

  dxl_fault_regs #(
    .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .SEXT_BIT(SEXT_BIT),
    .OPC_W(OPC_W), .RA_W(RA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .fire(fire), .code(code),
    .is_pte(req_pte_load), .is_nofault(req_nofault), .va(req_va),
    .opcode(inst_opcode), .ra(inst_ra), .flags(flags), .pt_base(pt_base),
    .fault_va(fault_va), .mm_stat(mm_stat), .va_form(va_form)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_pa    <= pa_full[PA_W-1:0];
      rsp_fault <= code;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_align_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ((req_va[2:0] & ~(3'b111 << req_size_lg)) != 3'b000) |=>
      rsp_fault == 3'd1);

  assert_hold_stall_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=>
      rsp_valid && $stable(rsp_pa) && $stable(rsp_fault));

  assert_sp_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !req_phys && req_size_lg == 2'd0 &&
    (&req_va[VA_W-1:SEXT_BIT]) && req_va[SP_HI:SP_LO] == SP_TAG &&
    cur_mode != '0 |=> rsp_fault == 3'd3);

  assert_phys_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_phys && req_size_lg == 2'd0 && req_va[VA_W-1:PA_W] != '0 |=>
      rsp_fault == 3'd6);
endmodule

// File: tb/sim_dxlate_checker.sv
module sim_dxlate_checker;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  localparam logic [63:0] PTB = 64'h0000_0002_0000_0000;
  localparam logic [5:0]  OPC = 6'h2C;
  localparam logic [4:0]  RAF = 5'h07;
  localparam logic [63:0] A   = 64'h0000_0000_1234_5678;
  localparam logic [63:0] S0  = 64'hFFFF_FC00_0001_2340;
  localparam logic [63:0] S1  = 64'hFFFF_FD00_0001_2340;

  typedef struct packed {
    logic [63:0] va; logic [1:0] sz; logic wr, ph, alt, pte, nf, pcl;
    logic [1:0] cur, altm; logic hit; logic [31:0] ppn;
    logic [3:0] rd, we; logic fr, fw;
    logic [2:0] code; logic [43:0] pa; logic lg; logic [5:0] fl;
  } vec_t;

  // va sz wr ph alt pte nf pcl cur altm hit ppn rd we fr fw | code pa lg flags
  localparam vec_t VT [NV] = '{
    '{A, 2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,1'b1,32'hABC,4'h1,4'h0,1'b0,1'b0, 3'd0,44'h0000157_9678,1'b0,6'h00}, // R7
    '{A+64'd2, 2'd2,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,1'b1,32'hABC,4'h1,4'h1,1'b0,1'b0, 3'd1,44'h0,1'b1,6'h01}, // R1
    '{64'h1003, 2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd2,2'd0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0, 3'd0,44'h1003,1'b0,6'h00}, // R12 phys
    '{64'h0000_1000_0000_0000, 2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0, 3'd6,44'h0,1'b0,6'h00}, // R12
    '{64'h0000_0400_0000_0000, 2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,1'b1,32'h0,4'hF,4'hF,1'b0,1'b0, 3'd2,44'h0,1'b1,6'h22}, // R3
    '{S0, 2'd3,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd2,2'd0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0, 3'd3,44'h0,1'b1,6'h03}, // R4
    '{S0, 2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0, 3'd0,44'h000_0001_2340,1'b0,6'h00}, // R5
    '{S1, 2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0, 3'd0,44'hF00_0001_2340,1'b0,6'h00}, // R5
    '{S0, 2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,2'd0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0, 3'd3,44'h0,1'b1,6'h02}, // R4 raw mode
    '{A, 2'd3,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,32'h0,4'hF,4'hF,1'b0,1'b0, 3'd4,44'h0,1'b1,6'h11}, // R6
    '{A, 2'd3,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,32'h0,4'hF,4'hF,1'b0,1'b0, 3'd5,44'h0,1'b0,6'h00}, // R6 R11
    '{A, 2'd3,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,1'b1,32'hABC,4'hF,4'h0,1'b0,1'b1, 3'd2,44'h0,1'b1,6'h0B}, // R8
    '{A, 2'd3,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,1'b1,32'hABC,4'h0,4'h1,1'b0,1'b1, 3'd2,44'h0,1'b1,6'h09}, // R8
    '{A, 2'd3,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,2'd0,1'b1,32'hABC,4'h0,4'hF,1'b1,1'b0, 3'd3,44'h0,1'b0,6'h00}, // R9 R11
    '{A, 2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,1'b1,32'hABC,4'h1,4'h0,1'b1,1'b0, 3'd2,44'h0,1'b1,6'h04}, // R9
    '{A, 2'd3,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'd0,2'd3,1'b1,32'hABC,4'h8,4'h0,1'b0,1'b0, 3'd0,44'h0000157_9678,1'b0,6'h00}, // R2
    '{A, 2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,2'd2,1'b1,32'hABC,4'h1,4'h0,1'b0,1'b0, 3'd0,44'h0000157_9678,1'b0,6'h00}, // R2
    '{A, 2'd3,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'd0,2'd2,1'b1,32'hABC,4'h1,4'h0,1'b0,1'b0, 3'd3,44'h0,1'b1,6'h02}, // R2
    '{A, 2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,1'b1,32'h8000_0000,4'h1,4'h0,1'b0,1'b0, 3'd6,44'h0,1'b0,6'h00}, // R12
    '{A+64'd1, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,2'd0,1'b1,32'hABC,4'h1,4'h0,1'b0,1'b0, 3'd1,44'h0,1'b0,6'h00}  // R1 R11
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b1, req_ready, rsp_valid;
  logic [63:0] req_va = '0, pt_base = PTB, fault_va, va_form;
  logic [1:0] req_size_lg = '0, cur_mode = '0, alt_mode = '0;
  logic req_write = 0, req_phys = 0, req_alt = 0, req_pte_load = 0, req_nofault = 0, pc_lsb = 0;
  logic [5:0] inst_opcode = OPC;
  logic [4:0] inst_ra = RAF;
  logic tlb_hit = 0, tlb_fonr = 0, tlb_fonw = 0;
  logic [31:0] tlb_ppn = '0;
  logic [3:0] tlb_rd_en = '0, tlb_wr_en = '0;
  logic [43:0] rsp_pa;
  logic [2:0] rsp_fault;
  logic [16:0] mm_stat;

  int n_chk = 0, n_err = 0;
  logic [63:0] e_fva = '0, e_form = '0;
  logic [16:0] e_stat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dxlate_checker u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_va = v.va; req_size_lg = v.sz; req_write = v.wr; req_phys = v.ph;
    req_alt = v.alt; req_pte_load = v.pte; req_nofault = v.nf; pc_lsb = v.pcl;
    cur_mode = v.cur; alt_mode = v.altm; tlb_hit = v.hit; tlb_ppn = v.ppn;
    tlb_rd_en = v.rd; tlb_wr_en = v.we; tlb_fonr = v.fr; tlb_fonw = v.fw;
  endtask

  task automatic log_expect(input logic [63:0] va, input logic [5:0] fl);
    e_fva = va; e_stat = {OPC, RAF, fl};
    e_form = PTB | ({34'b0, va[42:13]} << 3);
  endtask

  task automatic chk_regs(input string req);
    chk(fault_va == e_fva, req, fault_va, e_fva);
    chk(mm_stat == e_stat, req, 64'(mm_stat), 64'(e_stat));
    chk(va_form == e_form, req, va_form, e_form);
  endtask

  initial begin
    repeat (CLK_PERIOD * 30000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14: reset state
    chk(rsp_valid == 1'b0, "R14 rsp_valid", 64'(rsp_valid), 0);
    chk_regs("R14 regs");
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R13 ready when empty", 64'(req_ready), 1);

    for (int i = 0; i < NV; i++) begin
      drive(VT[i]);
      req_valid = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b1, $sformatf("R13 valid vec %0d", i), 64'(rsp_valid), 1);
      chk(rsp_fault == VT[i].code, $sformatf("code vec %0d (R1-R12 table)", i),
          64'(rsp_fault), 64'(VT[i].code));
      if (VT[i].code == 3'd0)
        chk(rsp_pa == VT[i].pa, $sformatf("pa vec %0d R5 R7", i), 64'(rsp_pa), 64'(VT[i].pa));
      if (VT[i].lg) log_expect(VT[i].va, VT[i].fl);
      chk_regs($sformatf("R10 R11 regs vec %0d", i));
    end

    // R13: back-pressure
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R13 drained", 64'(rsp_valid), 0);
    rsp_ready = 1'b0;
    drive(VT[0]);
    req_valid = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R13 ready low when full", 64'(req_ready), 0);
    drive(VT[1]);
    repeat (2) begin
      @(negedge clk);
      chk(rsp_pa == VT[0].pa, "R13 pa held", 64'(rsp_pa), 64'(VT[0].pa));
      chk(rsp_fault == 3'd0, "R13 code held", 64'(rsp_fault), 0);
      chk(fault_va == e_fva, "R13 stalled request not logged", fault_va, e_fva);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_fault == 3'd1, "R13 R1 accepted after stall", 64'(rsp_fault), 1);
    log_expect(VT[1].va, 6'h01);
    chk_regs("R10 after stall");
    req_valid = 1'b0;

    // R14: reset clears a logged state
    rst_n = 1'b0;
    @(negedge clk);
    e_fva = '0; e_stat = '0; e_form = '0;
    chk(rsp_valid == 1'b0, "R14 valid cleared", 64'(rsp_valid), 0);
    chk_regs("R14 regs cleared");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule